// File: doc/BRIEF.md
# Operand Forwarding and Load Interlock Unit

This block is the hazard-control logic of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It compares the source register numbers of the instruction now in execute with the destination numbers held in the two later pipeline registers. From that comparison it drives the selects of the bypass multiplexers in front of both ALU operand inputs. It also drives a select in front of the data-memory write-data input. A load result can then reach a store that follows it directly, through the memory-to-memory path.

A second part looks at the instruction in decode and the instruction in execute. When the instruction in execute is a load and the next instruction needs the loaded value as an ALU operand, the unit asserts three signals for one cycle. The fetch address and the fetch/decode register keep their contents, and a no-operation control word goes into the decode/execute register. The block is purely combinational. The ALU, the register file and the memories stay outside it.

Top module: `fwd_hazard_unit`

## Requirements
- R1: `alu_a_sel`/`alu_b_sel` use code 0 = register-file value, 1 = execute/memory ALU result, 2 = memory/write-back result. Code 1 is chosen when `mem_wr_en` is 1, `mem_is_load` is 0, `mem_rd` equals the operand's source number, and that number is not 0.
- R2: Code 2 is chosen when `wb_wr_en` is 1, `wb_rd` equals the source number, the number is not 0, and R1 does not apply. Otherwise the code is 0, so an operand whose producer has already left the pipeline is read from the register file.
- R3: When both later stages match the same source, the execute/memory (younger) result wins (code 1).
- R4: Register number 0 is never forwarded, and a producer with its write enable at 0 never causes forwarding.
- R5: The two operand selects are independent. Both may forward in the same cycle, from the same stage or from different stages.
- R6: A load that sits in the execute/memory register is never a forwarding source for the execute operands.
- R7: `st_data_sel` is 1 only when `mem_is_store` is 1, `wb_is_load` and `wb_wr_en` are 1, `wb_rd` is not 0 and `wb_rd` equals `mem_rs2`. In that case the loaded data replaces the carried store data. Otherwise it is 0.
- R8: `pc_hold`, `ifid_hold` and `idex_bubble` are asserted together when `ex_is_load` and `ex_wr_en` are 1, `ex_rd` is not 0, and `ex_rd` equals a decode-stage source that is in use (`id_rs1_used`, or `id_rs2_used` on a non-store).
- R9: A store in decode whose only link to the load in execute is its data operand (`id_rs2`) does not stall. A match on its address operand (`id_rs1`) does stall.
- R10: No stall is raised when the execute instruction is not a load, does not write, or targets register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_W | Decode-stage first source number |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2 | input | REG_W | Decode-stage second source number |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| id_is_store | input | 1 | Decode instruction is a store (second source is write data) |
| ex_rs1 | input | REG_W | Execute-stage first source number |
| ex_rs2 | input | REG_W | Execute-stage second source number |
| ex_rd | input | REG_W | Execute-stage destination number |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Execute/memory register destination number |
| mem_wr_en | input | 1 | Execute/memory instruction writes a register |
| mem_is_load | input | 1 | Execute/memory instruction is a load |
| mem_is_store | input | 1 | Execute/memory instruction is a store |
| mem_rs2 | input | REG_W | Store data source number carried into the memory stage |
| wb_rd | input | REG_W | Memory/write-back destination number |
| wb_wr_en | input | 1 | Memory/write-back instruction writes a register |
| wb_is_load | input | 1 | Memory/write-back instruction is a load |
| alu_a_sel | output | 2 | First operand bypass select (R1 code) |
| alu_b_sel | output | 2 | Second operand bypass select (R1 code) |
| st_data_sel | output | 1 | 1 = loaded data to memory write-data input |
| pc_hold | output | 1 | Keep the fetch address |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a no-operation into decode/execute |

## Verification
Directed patterns first put a match in only one later stage, then in both. They tell the younger-first priority apart from a plain OR, and a zero or write-disabled producer apart from a real one. Pairs that share a source, and pairs that split it, show that the two operand selects never leak into each other. Load cases place the load in each stage and the consumer as an ALU user, a store address or store data. These separate the memory-to-memory path from the stall path and show that a load in the memory stage is never a bypass source. A long run of random register numbers drawn from a small range then makes coincidental matches frequent, and every output is compared against an independent model on each clock.

// File: rtl/fwd_pkg.sv
// Shared encodings for the forwarding unit.
// Assumes: a two-bit select drives a three-input bypass multiplexer.
package fwd_pkg;
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EXMEM   = 2'd1,
        SRC_MEMWB   = 2'd2
    } src_sel_e;
endpackage

// File: rtl/fwd_operand_sel.sv
// Picks the bypass source for one execute-stage operand.
// Assumes: a load in the execute/memory register has no data yet, so it is
// never a source; the younger stage wins when both match.
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_idx,
    input  logic             exm_wr,
    input  logic             exm_ld,
    input  logic [REG_W-1:0] exm_rd,
    input  logic             mwb_wr,
    input  logic [REG_W-1:0] mwb_rd,
    output src_sel_e         sel
);
    logic src_live;
    logic hit_exm;
    logic hit_mwb;

    // Compare the source against both producers and apply priority.
    always_comb begin
        src_live = (src_idx != '0);
        hit_exm  = src_live && exm_wr && !exm_ld && (exm_rd == src_idx);
        hit_mwb  = src_live && mwb_wr && (mwb_rd == src_idx);
        if (hit_exm)
            sel = SRC_EXMEM;
        else if (hit_mwb)
            sel = SRC_MEMWB;
        else
            sel = SRC_REGFILE;
    end
endmodule

// File: rtl/fwd_store_sel.sv
// Memory-stage write-data select: routes a just-loaded value into a store.
// Assumes: the load sits in memory/write-back while the store is in memory.
module fwd_store_sel #(
    parameter int REG_W = 5
) (
    input  logic             st_valid,
    input  logic [REG_W-1:0] st_src,
    input  logic             ld_valid,
    input  logic             ld_wr,
    input  logic [REG_W-1:0] ld_rd,
    output logic             use_load
);
    // Match the store data source to the load destination.
    always_comb begin
        use_load = st_valid && ld_valid && ld_wr
                   && (ld_rd != '0) && (ld_rd == st_src);
    end
endmodule

// File: rtl/fwd_load_interlock.sv
// Detects a load in execute whose result the decode instruction needs as an
// ALU operand one cycle too early.
// Assumes: store data is patched later through the memory-stage path.
module fwd_load_interlock #(
    parameter int REG_W = 5
) (
    input  logic             ld_valid,
    input  logic             ld_wr,
    input  logic [REG_W-1:0] ld_rd,
    input  logic [REG_W-1:0] use_a,
    input  logic             use_a_en,
    input  logic [REG_W-1:0] use_b,
    input  logic             use_b_en,
    input  logic             use_is_store,
    output logic             hazard
);
    logic ld_live;
    logic dep_a;
    logic dep_b;

    // Raise the hazard when an operand in use needs the pending load.
    always_comb begin
        ld_live = ld_valid && ld_wr && (ld_rd != '0);
        dep_a   = use_a_en && (use_a == ld_rd);
        dep_b   = use_b_en && !use_is_store && (use_b == ld_rd);
        hazard  = ld_live && (dep_a || dep_b);
    end
endmodule

// File: rtl/fwd_hazard_unit.sv
// Top of the forwarding and interlock logic. Purely combinational.
// Assumes: register 0 reads as zero; ALU, register file, memories are outside.
module fwd_hazard_unit
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs1,
    input  logic             id_rs1_used,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_rs2_used,
    input  logic             id_is_store,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wr_en,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wr_en,
    input  logic             mem_is_load,
    input  logic             mem_is_store,
    input  logic [REG_W-1:0] mem_rs2,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wr_en,
    input  logic             wb_is_load,
    output logic [1:0]       alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic             st_data_sel,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble
);
    localparam int NUM_SRC = 2;

    logic [REG_W-1:0] src_vec [NUM_SRC];
    src_sel_e         sel_vec [NUM_SRC];
    logic             stall_w;

    // Gather the execute sources into an indexable array.
    always_comb begin
        src_vec[0] = ex_rs1;
        src_vec[1] = ex_rs2;
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
            fwd_operand_sel #(.REG_W(REG_W)) u_sel (
                .src_idx (src_vec[g]),
                .exm_wr  (mem_wr_en),
                .exm_ld  (mem_is_load),
                .exm_rd  (mem_rd),
                .mwb_wr  (wb_wr_en),
                .mwb_rd  (wb_rd),
                .sel     (sel_vec[g])
            );
        end
    endgenerate

    fwd_store_sel #(.REG_W(REG_W)) u_st (
        .st_valid (mem_is_store),
        .st_src   (mem_rs2),
        .ld_valid (wb_is_load),
        .ld_wr    (wb_wr_en),
        .ld_rd    (wb_rd),
        .use_load (st_data_sel)
    );

    fwd_load_interlock #(.REG_W(REG_W)) u_lk (
        .ld_valid     (ex_is_load),
        .ld_wr        (ex_wr_en),
        .ld_rd        (ex_rd),
        .use_a        (id_rs1),
        .use_a_en     (id_rs1_used),
        .use_b        (id_rs2),
        .use_b_en     (id_rs2_used),
        .use_is_store (id_is_store),
        .hazard       (stall_w)
    );

    // Drive the operand selects and fan the stall out to its three users.
    always_comb begin
        alu_a_sel   = sel_vec[0];
        alu_b_sel   = sel_vec[1];
        pc_hold     = stall_w;
        ifid_hold   = stall_w;
        idex_bubble = stall_w;
    end
endmodule

// File: rtl/fwd_hazard_chk.sv
// Checker for fwd_hazard_unit, attached by bind.
module fwd_hazard_chk #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] ex_rs1,
    input logic [REG_W-1:0] ex_rs2,
    input logic             ex_is_load,
    input logic [REG_W-1:0] mem_rd,
    input logic             mem_wr_en,
    input logic             mem_is_load,
    input logic             mem_is_store,
    input logic [1:0]       alu_a_sel,
    input logic [1:0]       alu_b_sel,
    input logic             st_data_sel,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             idex_bubble
);
    // Evaluate the output relations whenever any observed signal settles.
    always_comb begin
        // R3
        exm_prio_chk: assert (!(mem_wr_en && !mem_is_load && mem_rd != '0
                                && mem_rd == ex_rs1) || alu_a_sel == 2'd1)
            else $error("execute/memory match lost priority");
        // R4
        zero_reg_chk: assert (ex_rs2 != '0 || alu_b_sel == 2'd0)
            else $error("register 0 forwarded");
        // R6
        no_load_src_chk: assert (!(alu_a_sel == 2'd1 || alu_b_sel == 2'd1)
                                 || (mem_wr_en && !mem_is_load))
            else $error("load in memory stage used as source");
        // R7
        st_needs_store_chk: assert (!st_data_sel || mem_is_store)
            else $error("store-data select without a store");
        // R8
        stall_group_chk: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble)
            else $error("stall outputs disagree");
        // R10
        stall_needs_load_chk: assert (!pc_hold || ex_is_load)
            else $error("stall without a load in execute");
    end
endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.REG_W(REG_W)) u_chk (
    .ex_rs1       (ex_rs1),
    .ex_rs2       (ex_rs2),
    .ex_is_load   (ex_is_load),
    .mem_rd       (mem_rd),
    .mem_wr_en    (mem_wr_en),
    .mem_is_load  (mem_is_load),
    .mem_is_store (mem_is_store),
    .alu_a_sel    (alu_a_sel),
    .alu_b_sel    (alu_b_sel),
    .st_data_sel  (st_data_sel),
    .pc_hold      (pc_hold),
    .ifid_hold    (ifid_hold),
    .idex_bubble  (idex_bubble)
);

// File: tb/sim_fwd_hazard_unit.sv
// Bench: drives one stimulus per clock, compares at the falling edge against
// a behavioural model of the requirements.
module sim_fwd_hazard_unit;
    localparam int RW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
    logic id_rs1_used, id_rs2_used, id_is_store, ex_wr_en, ex_is_load;
    logic mem_wr_en, mem_is_load, mem_is_store, wb_wr_en, wb_is_load;
    logic [1:0] alu_a_sel, alu_b_sel;
    logic st_data_sel, pc_hold, ifid_hold, idex_bubble;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    fwd_hazard_unit #(.REG_W(RW)) u0 (.*);

    function automatic int model_sel(int src);
        if (src == 0) return 0;
        if (mem_wr_en && !mem_is_load && int'(mem_rd) == src) return 1;
        if (wb_wr_en && int'(wb_rd) == src) return 2;
        return 0;
    endfunction

    function automatic int model_st();
        if (mem_is_store && wb_is_load && wb_wr_en && wb_rd != 0 && wb_rd == mem_rs2)
            return 1;
        return 0;
    endfunction

    function automatic int model_stall();
        bit need;
        if (!(ex_is_load && ex_wr_en) || ex_rd == 0) return 0;
        need = (id_rs1_used && id_rs1 == ex_rd);
        if (id_rs2_used && !id_is_store && id_rs2 == ex_rd) need = 1'b1;
        return need ? 1 : 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_all();
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd} = '0;
        {id_rs1_used, id_rs2_used, id_is_store, ex_wr_en, ex_is_load} = '0;
        {mem_wr_en, mem_is_load, mem_is_store, wb_wr_en, wb_is_load} = '0;
    endtask

    // Wait for the falling edge, then compare every output with the model.
    task automatic settle_check(string tag);
        @(negedge clk);
        chk(tag, "alu_a_sel", int'(alu_a_sel), model_sel(int'(ex_rs1)));
        chk(tag, "alu_b_sel", int'(alu_b_sel), model_sel(int'(ex_rs2)));
        chk(tag, "st_data_sel", int'(st_data_sel), model_st());
        chk(tag, "pc_hold", int'(pc_hold), model_stall());
        chk(tag, "ifid_hold", int'(ifid_hold), model_stall());
        chk(tag, "idex_bubble", int'(idex_bubble), model_stall());
        @(posedge clk);
        clear_all();
    endtask

    initial begin
        clear_all();
        @(posedge clk);
        settle_check("R1 idle");
        chk("R1 idle", "a_sel fixed", int'(alu_a_sel), 0);

        ex_rs1 = 3; mem_wr_en = 1; mem_rd = 3;
        @(negedge clk); chk("R1", "a from exmem", int'(alu_a_sel), 1);
        @(posedge clk); settle_check("R1");

        ex_rs2 = 4; wb_wr_en = 1; wb_rd = 4;
        @(negedge clk); chk("R2", "b from memwb", int'(alu_b_sel), 2);
        @(posedge clk); settle_check("R2");

        ex_rs1 = 5; mem_wr_en = 1; mem_rd = 5; wb_wr_en = 1; wb_rd = 5;
        @(negedge clk); chk("R3", "younger wins", int'(alu_a_sel), 1);
        @(posedge clk); settle_check("R3");

        ex_rs1 = 0; ex_rs2 = 0; mem_wr_en = 1; mem_rd = 0; wb_wr_en = 1; wb_rd = 0;
        @(negedge clk); chk("R4", "reg0 a", int'(alu_a_sel), 0);
        chk("R4", "reg0 b", int'(alu_b_sel), 0);
        @(posedge clk); settle_check("R4");

        ex_rs1 = 7; mem_wr_en = 0; mem_rd = 7; wb_wr_en = 0; wb_rd = 7;
        @(negedge clk); chk("R4", "no write", int'(alu_a_sel), 0);
        @(posedge clk); settle_check("R4");

        ex_rs1 = 6; ex_rs2 = 6; mem_wr_en = 1; mem_rd = 6;
        @(negedge clk); chk("R5", "same a", int'(alu_a_sel), 1);
        chk("R5", "same b", int'(alu_b_sel), 1);
        @(posedge clk); settle_check("R5");

        ex_rs1 = 6; ex_rs2 = 9; mem_wr_en = 1; mem_rd = 6; wb_wr_en = 1; wb_rd = 9;
        @(negedge clk); chk("R5", "split a", int'(alu_a_sel), 1);
        chk("R5", "split b", int'(alu_b_sel), 2);
        @(posedge clk); settle_check("R5");

        ex_rs1 = 8; mem_wr_en = 1; mem_is_load = 1; mem_rd = 8;
        @(negedge clk); chk("R6", "load not source", int'(alu_a_sel), 0);
        @(posedge clk); settle_check("R6");

        ex_rs1 = 8; mem_wr_en = 1; mem_is_load = 1; mem_rd = 8; wb_wr_en = 1; wb_rd = 8;
        @(negedge clk); chk("R6", "falls to memwb", int'(alu_a_sel), 2);
        @(posedge clk); settle_check("R6");

        mem_is_store = 1; mem_rs2 = 9; wb_is_load = 1; wb_wr_en = 1; wb_rd = 9;
        @(negedge clk); chk("R7", "mem to mem", int'(st_data_sel), 1);
        @(posedge clk); settle_check("R7");

        mem_is_store = 1; mem_rs2 = 9; wb_is_load = 0; wb_wr_en = 1; wb_rd = 9;
        @(negedge clk); chk("R7", "not a load", int'(st_data_sel), 0);
        @(posedge clk); settle_check("R7");

        ex_is_load = 1; ex_wr_en = 1; ex_rd = 10; id_rs1 = 10; id_rs1_used = 1;
        @(negedge clk); chk("R8", "rs1 stall", int'(pc_hold), 1);
        chk("R8", "bubble", int'(idex_bubble), 1);
        @(posedge clk); settle_check("R8");

        ex_is_load = 1; ex_wr_en = 1; ex_rd = 10; id_rs2 = 10; id_rs2_used = 1;
        @(negedge clk); chk("R8", "rs2 stall", int'(ifid_hold), 1);
        @(posedge clk); settle_check("R8");

        ex_is_load = 1; ex_wr_en = 1; ex_rd = 10; id_rs1 = 10; id_rs1_used = 0;
        @(negedge clk); chk("R8", "unused src", int'(pc_hold), 0);
        @(posedge clk); settle_check("R8");

        ex_is_load = 1; ex_wr_en = 1; ex_rd = 11; id_is_store = 1;
        id_rs2 = 11; id_rs2_used = 1; id_rs1 = 2; id_rs1_used = 1;
        @(negedge clk); chk("R9", "store data no stall", int'(pc_hold), 0);
        @(posedge clk); settle_check("R9");

        ex_is_load = 1; ex_wr_en = 1; ex_rd = 11; id_is_store = 1;
        id_rs1 = 11; id_rs1_used = 1;
        @(negedge clk); chk("R9", "store addr stall", int'(pc_hold), 1);
        @(posedge clk); settle_check("R9");

        ex_is_load = 0; ex_wr_en = 1; ex_rd = 12; id_rs1 = 12; id_rs1_used = 1;
        @(negedge clk); chk("R10", "not load", int'(pc_hold), 0);
        @(posedge clk); settle_check("R10");

        ex_is_load = 1; ex_wr_en = 1; ex_rd = 0; id_rs1 = 0; id_rs1_used = 1;
        @(negedge clk); chk("R10", "rd zero", int'(pc_hold), 0);
        @(posedge clk); settle_check("R10");

        for (int i = 0; i < 3000; i++) begin
            id_rs1 = RW'($urandom_range(0, 3)); id_rs2 = RW'($urandom_range(0, 3));
            ex_rs1 = RW'($urandom_range(0, 3)); ex_rs2 = RW'($urandom_range(0, 3));
            ex_rd  = RW'($urandom_range(0, 3)); mem_rd = RW'($urandom_range(0, 3));
            mem_rs2 = RW'($urandom_range(0, 3)); wb_rd = RW'($urandom_range(0, 3));
            {id_rs1_used, id_rs2_used, id_is_store, ex_wr_en, ex_is_load} = 5'($urandom);
            {mem_wr_en, mem_is_load, mem_is_store, wb_wr_en, wb_is_load} = 5'($urandom);
            settle_check("R1 R2 R3 R5 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule